// File: doc/BRIEF.md
# Vectored Interrupt Controller with Return Stack

This block arbitrates interrupt requests for a small processor core and keeps the return addresses of interrupt entries. It holds ten sticky request flags: three core sources (timer overflow, an edge on an external pin, and a change on the upper nibble of a port) and seven peripheral sources. Each source has its own enable bit. A peripheral-group enable gates all seven peripheral flags together, and a global enable gates everything. Software clears the flags with clear pulses. Flags stay set until they are cleared.

When a request is pending and the core signals an instruction boundary, the controller does three things in one step. It drops the global enable, pushes the supplied return address onto an eight-entry circular stack, and loads the program counter with the interrupt vector. A return-from-interrupt strobe pops the stack, loads the program counter with the popped address and sets the global enable again. A wake request to the sleep logic is also produced. It comes from the enabled external-edge, port-change and comparator flags, without regard to the global or peripheral-group enables.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `gie_o`, `irq_o`, `wake_o`, `pc_load_o`, `pc_val_o` and all flags are 0. The external-pin history, the port latch and every stack entry also reset to 0.
- R2: A flag is set on the clock edge that samples its event. It stays set until a clear pulse for that bit. If set and clear fall on the same edge, the set wins. Core flag bits are: bit 0 timer overflow (set by `tmr_ovf_i`), bit 1 external edge, bit 2 port change. Peripheral flag bit i is set by `periph_set_i[i]`.
- R3: The external-edge flag is set when `ext_pin_i` differs from its value on the previous edge in the direction chosen by `edge_sel_i`: 1 for low-to-high, 0 for high-to-low. An edge in the other direction sets nothing.
- R4: The port-change flag is set on every edge where `port_pins_i` differs from an internal latch. The latch loads `port_pins_i` on each edge where `port_rd_i` is 1.
- R5: `irq_o` is 1 exactly when `gie_o` is 1 and either an enabled core flag is set or `peie_i` is 1 with an enabled peripheral flag set.
- R6: When `irq_o` and `accept_i` are 1 and `reti_i` is 0 at an edge, the next cycle shows `gie_o`=0, `pc_load_o`=1 and `pc_val_o`=0x0004, and `ret_addr_i` is pushed.
- R7: When `reti_i` is 1 at an edge, the next cycle shows `gie_o`=1, `pc_load_o`=1 and `pc_val_o` equal to the most recently pushed, not yet popped address. A return takes precedence over a simultaneous entry.
- R8: The stack has 8 entries in a ring. A ninth push overwrites the oldest entry. A pop past the bottom wraps around to the newest slot in the ring, with no error indication.
- R9: `wake_o` is 1 whenever an enabled external-edge flag, an enabled port-change flag or an enabled comparator flag (peripheral bit 5) is set. This holds independently of `gie_o` and `peie_i`.
- R10: A software write (`gie_wr_i`=1) loads `gie_wdata_i` into the global enable, visible on the next cycle. An entry or a return on the same edge overrides it.
- R11: `pc_load_o` is a one-cycle pulse. `pc_val_o` holds its last value when no entry or return occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_ovf_i | input | 1 | Timer overflow event pulse |
| ext_pin_i | input | 1 | External interrupt pin level |
| edge_sel_i | input | 1 | 1: rising edge, 0: falling edge |
| port_pins_i | input | 4 | Upper port pin levels |
| port_rd_i | input | 1 | Port read strobe, loads the change latch |
| periph_set_i | input | 7 | Peripheral event pulses |
| core_clr_i | input | 3 | Core flag clear pulses |
| periph_clr_i | input | 7 | Peripheral flag clear pulses |
| core_en_i | input | 3 | Core source enables |
| periph_en_i | input | 7 | Peripheral source enables |
| peie_i | input | 1 | Peripheral group enable |
| gie_wr_i | input | 1 | Software write of the global enable |
| gie_wdata_i | input | 1 | Value for the global enable write |
| accept_i | input | 1 | Instruction boundary, entry may occur |
| ret_addr_i | input | 13 | Return address to push on entry |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | Interrupt request to the core |
| wake_o | output | 1 | Wake request from sleep |
| gie_o | output | 1 | Global enable state |
| pc_load_o | output | 1 | Program counter load pulse |
| pc_val_o | output | 13 | Program counter load value |
| core_flags_o | output | 3 | Core flags |
| periph_flags_o | output | 7 | Peripheral flags |

## Verification
- **Flags and registered outputs:** every flag, `gie_o`, `pc_load_o` and `pc_val_o` change one cycle after the edge that samples their stimulus.
- **Combinational outputs:** `irq_o` and `wake_o` follow the flag, enable and `peie_i` state within the same cycle.
- **Sampling point:** the bench drives inputs on the falling edge and compares outputs 2 ns later. A reference model is updated on each rising edge from the inputs held at that edge, so each registered result is checked in the cycle it becomes due. `irq_o` and `wake_o` are checked against the model's state combined with the inputs currently applied.
- **Multi-cycle corners:** the stack-wrap and precedence cases are checked by running ten nested entries and ten returns back to back.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NCORE    = 3;
  localparam int NPERIPH  = 7;
  localparam int PORT_W   = 4;
  localparam int PC_W     = 13;
  localparam int STK_DEPTH = 8;
  localparam logic [PC_W-1:0] IRQ_VECTOR = 13'h0004;

  localparam int C_TMR  = 0;
  localparam int C_EXT  = 1;
  localparam int C_PORT = 2;

  localparam int P_TMR16 = 0;
  localparam int P_MATCH = 1;
  localparam int P_CCMP  = 2;
  localparam int P_TX    = 3;
  localparam int P_RX    = 4;
  localparam int P_CMP   = 5;
  localparam int P_NVM   = 6;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_ENTER,
    ACT_RETURN
  } irq_act_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_pkg::*;
#(
  parameter int NP = NPERIPH,
  parameter int PW = PORT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tmr_ovf_i,
  input  logic          ext_pin_i,
  input  logic          edge_sel_i,
  input  logic [PW-1:0] port_pins_i,
  input  logic          port_rd_i,
  input  logic [NP-1:0] periph_set_i,
  input  logic [NCORE-1:0] core_clr_i,
  input  logic [NP-1:0] periph_clr_i,
  output logic [NCORE-1:0] core_flags_o,
  output logic [NP-1:0] periph_flags_o
);
  logic [NCORE-1:0] core_q, core_d, core_set;
  logic [NP-1:0]    per_q, per_d;
  logic             ext_q, ext_d;
  logic [PW-1:0]    latch_q, latch_d;
  logic             ext_rise, ext_fall;

  always_comb begin
    ext_rise = ext_pin_i & ~ext_q;
    ext_fall = ~ext_pin_i & ext_q;
    core_set         = '0;
    core_set[C_TMR]  = tmr_ovf_i;
    core_set[C_EXT]  = edge_sel_i ? ext_rise : ext_fall;
    core_set[C_PORT] = (port_pins_i != latch_q);
    core_d  = (core_q & ~core_clr_i) | core_set;
    per_d   = (per_q & ~periph_clr_i) | periph_set_i;
    ext_d   = ext_pin_i;
    latch_d = port_rd_i ? port_pins_i : latch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q  <= '0;
      per_q   <= '0;
      ext_q   <= 1'b0;
      latch_q <= '0;
    end else begin
      core_q  <= core_d;
      per_q   <= per_d;
      ext_q   <= ext_d;
      latch_q <= latch_d;
    end
  end

  assign core_flags_o   = core_q;
  assign periph_flags_o = per_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NP = NPERIPH
) (
  input  logic             gie_i,
  input  logic             peie_i,
  input  logic [NCORE-1:0] core_flags_i,
  input  logic [NCORE-1:0] core_en_i,
  input  logic [NP-1:0]    periph_flags_i,
  input  logic [NP-1:0]    periph_en_i,
  output logic             irq_o,
  output logic             wake_o
);
  logic [NCORE-1:0] core_live;
  logic [NP-1:0]    per_live;
  logic [NCORE-1:0] core_wake_mask;
  logic [NP-1:0]    per_wake_mask;

  genvar gi;
  generate
    for (gi = 0; gi < NCORE; gi++) begin : g_cmask
      assign core_wake_mask[gi] = (gi == C_EXT) || (gi == C_PORT);
    end
    for (gi = 0; gi < NP; gi++) begin : g_pmask
      assign per_wake_mask[gi] = (gi == P_CMP);
    end
  endgenerate

  always_comb begin
    core_live = core_flags_i & core_en_i;
    per_live  = periph_flags_i & periph_en_i;
    irq_o  = gie_i & ((|core_live) | (peie_i & (|per_live)));
    wake_o = (|(core_live & core_wake_mask)) | (|(per_live & per_wake_mask));
  end
endmodule

// File: rtl/irq_ret_stack.sv
module irq_ret_stack
  import irq_pkg::*;
#(
  parameter int DEPTH = STK_DEPTH,
  parameter int DW    = PC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] top_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] ptr_q, ptr_d, ptr_dec;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] wrap_dec(input logic [AW-1:0] p);
    return (p == '0) ? AW'(DEPTH-1) : p - 1'b1;
  endfunction

  always_comb begin
    ptr_dec = wrap_dec(ptr_q);
    top_o   = mem_q[ptr_dec];
    ptr_d   = ptr_q;
    if (pop_i)       ptr_d = ptr_dec;
    else if (push_i) ptr_d = wrap_inc(ptr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_slot
      logic wen;
      assign wen = push_i & ~pop_i & (ptr_q == AW'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   mem_q[gi] <= '0;
        else if (wen) mem_q[gi] <= din_i;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tmr_ovf_i,
  input  logic                ext_pin_i,
  input  logic                edge_sel_i,
  input  logic [PORT_W-1:0]   port_pins_i,
  input  logic                port_rd_i,
  input  logic [NPERIPH-1:0]  periph_set_i,
  input  logic [NCORE-1:0]    core_clr_i,
  input  logic [NPERIPH-1:0]  periph_clr_i,
  input  logic [NCORE-1:0]    core_en_i,
  input  logic [NPERIPH-1:0]  periph_en_i,
  input  logic                peie_i,
  input  logic                gie_wr_i,
  input  logic                gie_wdata_i,
  input  logic                accept_i,
  input  logic [PC_W-1:0]     ret_addr_i,
  input  logic                reti_i,
  output logic                irq_o,
  output logic                wake_o,
  output logic                gie_o,
  output logic                pc_load_o,
  output logic [PC_W-1:0]     pc_val_o,
  output logic [NCORE-1:0]    core_flags_o,
  output logic [NPERIPH-1:0]  periph_flags_o
);
  logic            gie_q, gie_d;
  logic            ld_q, ld_d;
  logic [PC_W-1:0] pcv_q, pcv_d;
  logic [PC_W-1:0] stk_top;
  logic            irq_w;
  irq_act_e        act;

  irq_flag_bank #(.NP(NPERIPH), .PW(PORT_W)) u_flags (
    .clk            (clk),
    .rst_n          (rst_n),
    .tmr_ovf_i      (tmr_ovf_i),
    .ext_pin_i      (ext_pin_i),
    .edge_sel_i     (edge_sel_i),
    .port_pins_i    (port_pins_i),
    .port_rd_i      (port_rd_i),
    .periph_set_i   (periph_set_i),
    .core_clr_i     (core_clr_i),
    .periph_clr_i   (periph_clr_i),
    .core_flags_o   (core_flags_o),
    .periph_flags_o (periph_flags_o)
  );

  irq_arbiter #(.NP(NPERIPH)) u_arb (
    .gie_i          (gie_q),
    .peie_i         (peie_i),
    .core_flags_i   (core_flags_o),
    .core_en_i      (core_en_i),
    .periph_flags_i (periph_flags_o),
    .periph_en_i    (periph_en_i),
    .irq_o          (irq_w),
    .wake_o         (wake_o)
  );

  always_comb begin
    if (reti_i)                  act = ACT_RETURN;
    else if (irq_w && accept_i)  act = ACT_ENTER;
    else                         act = ACT_NONE;
  end

  irq_ret_stack #(.DEPTH(STK_DEPTH), .DW(PC_W)) u_stack (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (act == ACT_ENTER),
    .pop_i  (act == ACT_RETURN),
    .din_i  (ret_addr_i),
    .top_o  (stk_top)
  );

  always_comb begin
    gie_d = gie_wr_i ? gie_wdata_i : gie_q;
    ld_d  = 1'b0;
    pcv_d = pcv_q;
    unique case (act)
      ACT_ENTER: begin
        gie_d = 1'b0;
        ld_d  = 1'b1;
        pcv_d = IRQ_VECTOR;
      end
      ACT_RETURN: begin
        gie_d = 1'b1;
        ld_d  = 1'b1;
        pcv_d = stk_top;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      ld_q  <= 1'b0;
      pcv_q <= '0;
    end else begin
      gie_q <= gie_d;
      ld_q  <= ld_d;
      pcv_q <= pcv_d;
    end
  end

  assign irq_o     = irq_w;
  assign gie_o     = gie_q;
  assign pc_load_o = ld_q;
  assign pc_val_o  = pcv_q;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
  import irq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               irq_o,
  input logic               wake_o,
  input logic               gie_o,
  input logic               pc_load_o,
  input logic [PC_W-1:0]    pc_val_o,
  input logic               accept_i,
  input logic               reti_i,
  input logic               peie_i,
  input logic [NCORE-1:0]   core_en_i,
  input logic [NCORE-1:0]   core_clr_i,
  input logic [NPERIPH-1:0] periph_clr_i,
  input logic [NCORE-1:0]   core_flags_o,
  input logic [NPERIPH-1:0] periph_flags_o
);
  a_r2_core_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (core_flags_o != '0) |=>
      ((core_flags_o & $past(core_flags_o & ~core_clr_i)) == $past(core_flags_o & ~core_clr_i)));

  a_r2_periph_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_flags_o != '0) |=>
      ((periph_flags_o & $past(periph_flags_o & ~periph_clr_i)) == $past(periph_flags_o & ~periph_clr_i)));

  a_r5_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> gie_o);

  a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!peie_i && ((core_flags_o & core_en_i) == '0)) |-> !irq_o);

  a_r6_enter_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && accept_i && !reti_i) |=> (!gie_o && pc_load_o && pc_val_o == IRQ_VECTOR));

  a_r7_return: assert property (@(posedge clk) disable iff (!rst_n)
    reti_i |=> (gie_o && pc_load_o));

  a_r11_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!reti_i && !(irq_o && accept_i)) |=> (!pc_load_o && $stable(pc_val_o)));

  a_r9_wake_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (core_flags_o[C_EXT] && core_en_i[C_EXT]) |-> wake_o);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .irq_o          (irq_o),
  .wake_o         (wake_o),
  .gie_o          (gie_o),
  .pc_load_o      (pc_load_o),
  .pc_val_o       (pc_val_o),
  .accept_i       (accept_i),
  .reti_i         (reti_i),
  .peie_i         (peie_i),
  .core_en_i      (core_en_i),
  .core_clr_i     (core_clr_i),
  .periph_clr_i   (periph_clr_i),
  .core_flags_o   (core_flags_o),
  .periph_flags_o (periph_flags_o)
);

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic tmr_ovf_i, ext_pin_i, edge_sel_i, port_rd_i, peie_i;
  logic gie_wr_i, gie_wdata_i, accept_i, reti_i;
  logic [3:0]  port_pins_i;
  logic [6:0]  periph_set_i, periph_clr_i, periph_en_i;
  logic [2:0]  core_clr_i, core_en_i;
  logic [12:0] ret_addr_i;
  logic        irq_o, wake_o, gie_o, pc_load_o;
  logic [12:0] pc_val_o;
  logic [2:0]  core_flags_o;
  logic [6:0]  periph_flags_o;

  int n_run = 0;
  int n_fail = 0;
  string phase = "R1";

  // reference model state
  logic        m_gie, m_ld, m_ext;
  logic [12:0] m_pcv;
  logic [2:0]  m_core;
  logic [6:0]  m_per;
  logic [3:0]  m_latch;
  logic [12:0] m_stk [8];
  int          m_ptr;

  always #4 clk = ~clk;

  irq_vector_ctrl dut (.*);

  function automatic logic model_irq();
    return m_gie && (((m_core & core_en_i) != 0) || (peie_i && ((m_per & periph_en_i) != 0)));
  endfunction

  function automatic logic model_wake();
    return (m_core[1] & core_en_i[1]) | (m_core[2] & core_en_i[2]) | (m_per[5] & periph_en_i[5]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gie = 0; m_ld = 0; m_ext = 0; m_pcv = 0;
      m_core = 0; m_per = 0; m_latch = 0; m_ptr = 0;
      for (int i = 0; i < 8; i++) m_stk[i] = 0;
    end else begin
      logic irq_now, enter;
      logic [2:0] cset;
      irq_now = model_irq();
      enter = irq_now && accept_i && !reti_i;
      cset[0] = tmr_ovf_i;
      cset[1] = edge_sel_i ? (ext_pin_i && !m_ext) : (!ext_pin_i && m_ext);
      cset[2] = (port_pins_i != m_latch);
      m_core = (m_core & ~core_clr_i) | cset;
      m_per  = (m_per & ~periph_clr_i) | periph_set_i;
      m_ext  = ext_pin_i;
      if (port_rd_i) m_latch = port_pins_i;
      if (gie_wr_i) m_gie = gie_wdata_i;
      m_ld = 0;
      if (reti_i) begin
        m_ptr = (m_ptr + 7) % 8;
        m_pcv = m_stk[m_ptr];
        m_gie = 1; m_ld = 1;
      end else if (enter) begin
        m_stk[m_ptr] = ret_addr_i;
        m_ptr = (m_ptr + 1) % 8;
        m_pcv = 13'h0004;
        m_gie = 0; m_ld = 1;
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    chk("irq_o", 32'(irq_o), 32'(model_irq()));
    chk("wake_o", 32'(wake_o), 32'(model_wake()));
    chk("gie_o", 32'(gie_o), 32'(m_gie));
    chk("pc_load_o", 32'(pc_load_o), 32'(m_ld));
    chk("pc_val_o", 32'(pc_val_o), 32'(m_pcv));
    chk("core_flags_o", 32'(core_flags_o), 32'(m_core));
    chk("periph_flags_o", 32'(periph_flags_o), 32'(m_per));
  end

  task automatic tick();
    @(negedge clk);
    tmr_ovf_i = 0; port_rd_i = 0; periph_set_i = 0; core_clr_i = 0; periph_clr_i = 0;
    gie_wr_i = 0; accept_i = 0; reti_i = 0;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired in phase %s", phase);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0;
    tmr_ovf_i = 0; ext_pin_i = 0; edge_sel_i = 0; port_rd_i = 0; peie_i = 0;
    gie_wr_i = 0; gie_wdata_i = 0; accept_i = 0; reti_i = 0;
    port_pins_i = 0; periph_set_i = 0; periph_clr_i = 0; periph_en_i = 0;
    core_clr_i = 0; core_en_i = 0; ret_addr_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R1 reset"; tick(); tick();

    phase = "R10 sw gie"; gie_wr_i = 1; gie_wdata_i = 1; tick();
    phase = "R2 timer flag"; core_en_i = 3'b001; tmr_ovf_i = 1; tick(); tick();
    phase = "R6 entry"; accept_i = 1; ret_addr_i = 13'h123; tick(); tick();
    phase = "R2 clear"; core_clr_i = 3'b001; tick(); tick();
    phase = "R7 return"; reti_i = 1; tick(); tick();
    phase = "R11 hold"; tick(); tick();

    phase = "R3 rising"; core_en_i = 0; edge_sel_i = 1; ext_pin_i = 1; tick(); tick();
    core_clr_i = 3'b010; tick();
    phase = "R3 wrong dir"; ext_pin_i = 0; tick(); tick();
    phase = "R3 falling"; edge_sel_i = 0; ext_pin_i = 1; tick(); ext_pin_i = 0; tick(); tick();
    core_clr_i = 3'b010; tick();

    phase = "R4 port change"; port_pins_i = 4'b1010; tick(); tick();
    phase = "R4 clear loses"; core_clr_i = 3'b100; tick(); tick();
    phase = "R4 read latch"; port_rd_i = 1; tick();
    core_clr_i = 3'b100; tick(); tick();

    phase = "R5 peie off"; periph_en_i = 7'h01; periph_set_i = 7'h01; tick(); tick();
    phase = "R5 peie on"; peie_i = 1; tick(); tick();
    peie_i = 0; periph_clr_i = 7'h7f; tick();

    phase = "R9 wake"; gie_wr_i = 1; gie_wdata_i = 0; tick();
    core_en_i = 3'b110; port_pins_i = 4'b0000; tick(); tick();
    core_clr_i = 3'b100; port_rd_i = 1; tick(); tick();
    periph_en_i = 7'h20; periph_set_i = 7'h20; tick(); tick();
    periph_clr_i = 7'h20; tick();
    periph_en_i = 0; core_en_i = 3'b001; tick();

    phase = "R8 push ring";
    for (int i = 0; i < 10; i++) begin
      gie_wr_i = 1; gie_wdata_i = 1; tmr_ovf_i = 1; tick();
      accept_i = 1; ret_addr_i = 13'(13'h100 + i); tick();
      core_clr_i = 3'b001; tick();
    end
    phase = "R7 precedence"; tmr_ovf_i = 1; gie_wr_i = 1; gie_wdata_i = 1; tick(); tick();
    reti_i = 1; accept_i = 1; ret_addr_i = 13'h1ff; tick(); tick();
    core_clr_i = 3'b001; tick();
    phase = "R8 pop wrap";
    for (int i = 0; i < 10; i++) begin
      reti_i = 1; tick(); tick();
    end
    phase = "R10 override"; gie_wr_i = 1; gie_wdata_i = 0; reti_i = 1; tick(); tick();
    tick();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule